// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This block holds four alarm bytes (seconds, minutes, hours, day of month) in BCD and compares them against a running BCD time of day. The time comes from an external counter, together with a one-second strobe. The comparison is made once per strobe. When the fields that take part all agree, the block emits a single-cycle interrupt pulse.

Bit 7 of each alarm byte is a repeat mask. The pattern of the four masks chooses how often the alarm recurs: monthly, daily, hourly, every minute or every second. Writes to the alarm bytes pass through a range check. A write that fails the check is dropped without notice, and the byte keeps its previous contents. A registered read port returns any alarm byte exactly as it was stored.

Top module: `bcd_alarm_match`

## Requirements
- R1: Select code 0 addresses the seconds byte, 1 the minutes byte, 2 the hours byte and 3 the date byte. An accepted write stores all 8 bits, including the bit-7 mask. `rd_data` shows the selected byte one clock after `rd_sel` is sampled.
- R2: A seconds or minutes write is accepted only when bits 6:4 are at most 5 and bits 3:0 are at most 9, which means BCD 00 to 59. Any other write leaves the byte unchanged.
- R3: An hours write is accepted only when bits 5:0 form BCD 00 to 23: tens bits 5:4 are 0 or 1 with a ones digit of 0 to 9, or tens is 2 with a ones digit of 0 to 3. Any other write leaves the byte unchanged.
- R4: A date write is accepted only when bits 3:0 are at most 9 and bits 4:0 are not zero. Any other write leaves the byte unchanged.
- R5: A synchronous active-high reset clears all four alarm bytes to 0x00, holds the interrupt low and clears `rd_data`.
- R6: With all four masks clear, an alarm fires only when seconds bits 6:0, minutes bits 6:0, hours bits 5:0 and date bits 5:0 all equal the same bits of the current time.
- R7: With only the date mask set, the date is ignored. Seconds, minutes and hours must all match.
- R8: With the date and hours masks set and the other two clear, only seconds and minutes must match.
- R9: With the date, hours and minutes masks set and the seconds mask clear, only seconds must match.
- R10: Every other mask pattern fires on every strobe, whatever the current time.
- R11: `irq_pulse` goes high for exactly one clock, in the cycle after the clock edge that sampled `tick` high with a match. The comparison uses the alarm bytes as they stood before that edge. There is never a pulse without a strobe, and never more than one pulse per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the alarm byte chosen by `wr_sel` |
| wr_sel | input | 2 | Alarm byte select for writes |
| wr_data | input | 8 | Write data, BCD value plus bit-7 mask |
| rd_sel | input | 2 | Alarm byte select for reads |
| rd_data | output | 8 | Registered read data |
| tick | input | 1 | One-second strobe, one clock wide |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| irq_pulse | output | 1 | Single-cycle alarm interrupt |

## Verification
Every result of this block sits one register away from its stimulus. An alarm byte changes at the edge that samples `wr_en`. Read data appears one edge after `rd_sel` is sampled. The interrupt rises at the edge that samples `tick` and falls at the next edge. The bench drives inputs on falling edges. It samples `irq_pulse` on the falling edge right after a strobe, then again one cycle later to confirm the pulse has ended. It reads each alarm byte back on the falling edge after the select was presented, so a rejected write shows up as an unchanged byte at the read port.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 4;

  // field select codes; the order is fixed by the register map
  localparam logic [1:0] FLD_SEC  = 2'd0;
  localparam logic [1:0] FLD_MIN  = 2'd1;
  localparam logic [1:0] FLD_HOUR = 2'd2;
  localparam logic [1:0] FLD_DATE = 2'd3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } rate_e;

  function automatic logic digit_ok(input logic [3:0] d);
    return d <= 4'd9;
  endfunction

  // range check applied to a write before it is stored
  function automatic logic field_write_ok(input logic [1:0] fld,
                                          input logic [BYTE_W-1:0] v);
    logic ok;
    case (fld)
      FLD_SEC, FLD_MIN: ok = (v[6:4] <= 3'd5) && digit_ok(v[3:0]);
      FLD_HOUR: ok = ((v[5:4] <= 2'd1) && digit_ok(v[3:0])) ||
                     ((v[5:4] == 2'd2) && (v[3:0] <= 4'd3));
      default:  ok = digit_ok(v[3:0]) && (v[4:0] != 5'd0);
    endcase
    return ok;
  endfunction

  // bits of a field that take part in the comparison
  function automatic logic [BYTE_W-1:0] field_cmp_mask(input logic [1:0] fld);
    logic [BYTE_W-1:0] m;
    case (fld)
      FLD_SEC, FLD_MIN: m = 8'h7F;
      default:          m = 8'h3F;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alarm_reg_bank.sv
module alarm_reg_bank
  import bcd_alarm_pkg::*;
#(
  parameter int N_FLD = NUM_FIELDS,
  parameter int DW    = BYTE_W,
  parameter int SW    = $clog2(N_FLD)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SW-1:0]             wr_sel,
  input  logic [DW-1:0]             wr_data,
  input  logic [SW-1:0]             rd_sel,
  output logic [DW-1:0]             rd_data,
  output logic [N_FLD-1:0][DW-1:0]  alarm_q
);

  for (genvar i = 0; i < N_FLD; i++) begin : g_fld
    localparam logic [SW-1:0] IDX = SW'(i);
    logic accept;

    always_comb accept = wr_en && (wr_sel == IDX) &&
                         field_write_ok(2'(i), wr_data);

    always_ff @(posedge clk) begin
      if (rst)         alarm_q[i] <= '0;
      else if (accept) alarm_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= alarm_q[rd_sel];
  end

endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode
  import bcd_alarm_pkg::*;
#(
  parameter int N_FLD = NUM_FIELDS
) (
  input  logic [N_FLD-1:0] mask,   // {date, hour, min, sec}
  output rate_e            rate,
  output logic [N_FLD-1:0] used    // fields that must match
);

  always_comb begin
    case (mask)
      4'b0000: rate = RPT_MONTH;
      4'b1000: rate = RPT_DAY;
      4'b1100: rate = RPT_HOUR;
      4'b1110: rate = RPT_MINUTE;
      default: rate = RPT_SECOND;
    endcase
  end

  always_comb begin
    case (rate)
      RPT_MONTH:  used = 4'b1111;
      RPT_DAY:    used = 4'b0111;
      RPT_HOUR:   used = 4'b0011;
      RPT_MINUTE: used = 4'b0001;
      default:    used = 4'b0000;
    endcase
  end

endmodule

// File: rtl/alarm_match_core.sv
module alarm_match_core
  import bcd_alarm_pkg::*;
#(
  parameter int N_FLD = NUM_FIELDS,
  parameter int DW    = BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic [N_FLD-1:0][DW-1:0] cur_vec,
  input  logic [N_FLD-1:0][DW-1:0] alarm_q,
  input  logic [N_FLD-1:0]         used,
  output logic                     irq_pulse
);

  logic [N_FLD-1:0] hit;

  for (genvar i = 0; i < N_FLD; i++) begin : g_cmp
    localparam logic [DW-1:0] CMASK = field_cmp_mask(2'(i));
    always_comb hit[i] = !used[i] ||
                         ((alarm_q[i] & CMASK) == (cur_vec[i] & CMASK));
  end

  always_ff @(posedge clk) begin
    if (rst) irq_pulse <= 1'b0;
    else     irq_pulse <= tick && (&hit);
  end

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
#(
  parameter int DW    = BYTE_W,
  parameter int N_FLD = NUM_FIELDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          tick,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_date,
  output logic          irq_pulse
);

  localparam int SW = $clog2(N_FLD);

  logic [N_FLD-1:0][DW-1:0] alarm_q;
  logic [N_FLD-1:0][DW-1:0] cur_vec;
  logic [N_FLD-1:0]         mask_bits;
  logic [N_FLD-1:0]         used;
  rate_e                    rate;

  always_comb cur_vec = {cur_date, cur_hour, cur_min, cur_sec};

  for (genvar i = 0; i < N_FLD; i++) begin : g_mask
    always_comb mask_bits[i] = alarm_q[i][DW-1];
  end

  alarm_reg_bank #(.N_FLD(N_FLD), .DW(DW), .SW(SW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .alarm_q (alarm_q)
  );

  alarm_rate_decode #(.N_FLD(N_FLD)) u_rate (
    .mask (mask_bits),
    .rate (rate),
    .used (used)
  );

  alarm_match_core #(.N_FLD(N_FLD), .DW(DW)) u_match (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cur_vec   (cur_vec),
    .alarm_q   (alarm_q),
    .used      (used),
    .irq_pulse (irq_pulse)
  );

endmodule

// File: rtl/bcd_alarm_match_chk.sv
module bcd_alarm_match_chk (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [7:0]      wr_data,
  input logic            tick,
  input logic            irq_pulse,
  input logic [3:0][7:0] alarm_q
);

  // R2
  sec_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && wr_data[6:0] > 7'h59) |=> $stable(alarm_q[0]));

  // R1
  sec_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && wr_data[6:4] <= 3'd5 && wr_data[3:0] <= 4'd9)
      |=> (alarm_q[0] == $past(wr_data)));

  // R3
  hour_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && wr_data[5:0] > 6'h23) |=> $stable(alarm_q[2]));

  // R4
  date_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3 && wr_data[4:0] == 5'd0) |=> $stable(alarm_q[3]));

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (alarm_q == '0 && !irq_pulse));

  // R10
  every_second_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !alarm_q[3][7] && (alarm_q[0][7] || alarm_q[1][7] || alarm_q[2][7]))
      |=> irq_pulse);

  // R11
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(tick));

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse && !tick) |=> !irq_pulse);

endmodule

bind bcd_alarm_match bcd_alarm_match_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .tick      (tick),
  .irq_pulse (irq_pulse),
  .alarm_q   (alarm_q)
);

// File: tb/bcd_alarm_match_test.sv
module bcd_alarm_match_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = 8'h01;
  logic       irq_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bcd_alarm_match uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .irq_pulse(irq_pulse)
  );

  // {alarm s,m,h,d, current s,m,h,d, expected pulse}
  localparam logic [64:0] VEC [12] = '{
    {8'h56, 8'h34, 8'h12, 8'h15, 8'h56, 8'h34, 8'h12, 8'h15, 1'b1}, // R6
    {8'h56, 8'h34, 8'h12, 8'h15, 8'h56, 8'h34, 8'h12, 8'h16, 1'b0}, // R6
    {8'h56, 8'h34, 8'h12, 8'h25, 8'h56, 8'h34, 8'h12, 8'h25, 1'b1}, // R6 date tens 2
    {8'h56, 8'h34, 8'h12, 8'h95, 8'h56, 8'h34, 8'h12, 8'h28, 1'b1}, // R7
    {8'h56, 8'h34, 8'h12, 8'h95, 8'h56, 8'h34, 8'h13, 8'h15, 1'b0}, // R7
    {8'h56, 8'h34, 8'h92, 8'h95, 8'h56, 8'h34, 8'h07, 8'h03, 1'b1}, // R8
    {8'h56, 8'h34, 8'h92, 8'h95, 8'h56, 8'h35, 8'h12, 8'h15, 1'b0}, // R8
    {8'h56, 8'hB4, 8'h92, 8'h95, 8'h56, 8'h01, 8'h22, 8'h30, 1'b1}, // R9
    {8'h56, 8'hB4, 8'h92, 8'h95, 8'h57, 8'h34, 8'h12, 8'h15, 1'b0}, // R9
    {8'hD6, 8'h34, 8'h12, 8'h15, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R10
    {8'h56, 8'h34, 8'h92, 8'h15, 8'h11, 8'h22, 8'h08, 8'h09, 1'b1}, // R10
    {8'hD6, 8'hB4, 8'h92, 8'h95, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1}  // R10
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    d = rd_data;
  endtask

  // strobe once; returns pulse level in the cycle after and one cycle later
  task automatic strobe(input logic [7:0] s, m, h, dt,
                        output logic got, output logic after);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = dt; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    got = irq_pulse;
    @(negedge clk);
    after = irq_pulse;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic g, a;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R5: reset state
    check("R5 irq after reset", {7'd0, irq_pulse}, 8'h00);
    for (int f = 0; f < 4; f++) begin
      rd(2'(f), v);
      check("R5 byte cleared", v, 8'h00);
    end

    // vector table
    for (int k = 0; k < 12; k++) begin
      wr(2'd0, VEC[k][64:57]);
      wr(2'd1, VEC[k][56:49]);
      wr(2'd2, VEC[k][48:41]);
      wr(2'd3, VEC[k][40:33]);
      strobe(VEC[k][32:25], VEC[k][24:17], VEC[k][16:9], VEC[k][8:1], g, a);
      check($sformatf("R6-R10 vector %0d", k), {7'd0, g}, {7'd0, VEC[k][0]});
      check("R11 pulse one cycle", {7'd0, a}, 8'h00);
    end

    // R1: readback with mask bit, all fields
    wr(2'd0, 8'hD6); rd(2'd0, v); check("R1 sec readback", v, 8'hD6);
    wr(2'd1, 8'h59); rd(2'd1, v); check("R1 min readback", v, 8'h59);
    // R2: rejected seconds / minutes
    wr(2'd0, 8'h60); rd(2'd0, v); check("R2 sec 60 rejected", v, 8'hD6);
    wr(2'd0, 8'h5A); rd(2'd0, v); check("R2 sec bad digit rejected", v, 8'hD6);
    wr(2'd1, 8'hF0); rd(2'd1, v); check("R2 min 70 rejected", v, 8'h59);
    // R3: hours
    wr(2'd2, 8'h23); rd(2'd2, v); check("R3 hour 23 accepted", v, 8'h23);
    wr(2'd2, 8'h24); rd(2'd2, v); check("R3 hour 24 rejected", v, 8'h23);
    wr(2'd2, 8'h1A); rd(2'd2, v); check("R3 hour bad digit rejected", v, 8'h23);
    // R4: date
    wr(2'd3, 8'h31); rd(2'd3, v); check("R4 date 31 accepted", v, 8'h31);
    wr(2'd3, 8'h00); rd(2'd3, v); check("R4 date 0 rejected", v, 8'h31);
    wr(2'd3, 8'hE0); rd(2'd3, v); check("R4 date low bits 0 rejected", v, 8'h31);
    wr(2'd3, 8'h0B); rd(2'd3, v); check("R4 date bad digit rejected", v, 8'h31);

    // R11: no pulse without a strobe while in every-second mode
    @(negedge clk);
    cur_sec = 8'h56;
    repeat (4) @(negedge clk);
    check("R11 no pulse without tick", {7'd0, irq_pulse}, 8'h00);
    strobe(8'h10, 8'h20, 8'h05, 8'h07, g, a);
    check("R11 pulse after tick", {7'd0, g}, 8'h01);
    check("R11 pulse ends", {7'd0, a}, 8'h00);

    // R11: write in the strobe cycle uses the previous byte value
    wr(2'd0, 8'h56); wr(2'd1, 8'h34); wr(2'd2, 8'h12); wr(2'd3, 8'h15);
    @(negedge clk);
    cur_sec = 8'h56; cur_min = 8'h34; cur_hour = 8'h12; cur_date = 8'h15;
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R11 compare uses old byte", {7'd0, irq_pulse}, 8'h01);

    // R5: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(2'd1, v); check("R5 reset clears min", v, 8'h00);

    done = 1'b1;
    finish_run();
  end

endmodule